// File: doc/BRIEF.md
# Four-Bit Adder-Subtractor with BCD / Excess-3 Conversion

This block is a purely combinational arithmetic unit. One ripple adder core does four jobs, and a two-bit mode input picks the job. It can add two unsigned operands. It can subtract them in two's complement, with the sign taken from the adder's carry-out. It can turn a BCD digit into Excess-3 code, or an Excess-3 digit back into BCD. The two code conversions work by feeding a fixed constant into the adder's second operand, so in those modes the B input is not used.

In subtract mode a carry-out of 1 means the difference is zero or positive, and the raw result is the difference itself. A carry-out of 0 means the difference is negative, and the raw result is in two's-complement form. A separate magnitude output always gives the absolute value, and a sign flag marks the negative case. In the two conversion modes, a digit outside the legal code range raises a flag, but the converted value is still produced.

The unit carries no data stream and has no clock. Every output settles from the inputs in the same evaluation, so the block has no valid/ready pair and no back-pressure.

Top module: `addsub_codeconv`

## Requirements
- R1: With mode_i = 2'b00 (add), sum_o equals (a_i + b_i) mod 16 and carry_o equals bit 4 of the five-bit sum a_i + b_i.
- R2: With mode_i = 2'b01 (subtract), sum_o equals (a_i - b_i) mod 16, and carry_o is 1 exactly when a_i >= b_i.
- R3: neg_o is 1 only when mode_i = 2'b01 and a_i < b_i. In every other mode, and for every other operand pair, neg_o is 0.
- R4: In subtract mode mag_o equals |a_i - b_i|. In all other modes mag_o equals sum_o.
- R5: With mode_i = 2'b10 (BCD to Excess-3), sum_o equals (a_i + 3) mod 16 and carry_o equals bit 4 of a_i + 3. The value of b_i has no effect on any output.
- R6: With mode_i = 2'b11 (Excess-3 to BCD), sum_o equals (a_i - 3) mod 16 and carry_o is 1 exactly when a_i >= 3. The value of b_i has no effect on any output.
- R7: code_bad_o is 1 in mode 2'b10 when a_i > 9, and in mode 2'b11 when a_i < 3 or a_i > 12. It is 0 otherwise, including in both arithmetic modes.
- R8: Two fixed subtractions hold. 8 - 3 gives sum_o = 4'b0101 with carry_o = 1. 14 - 15 gives sum_o = 4'b1111, carry_o = 0, neg_o = 1 and mag_o = 4'b0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand, or the digit to convert |
| b_i | input | 4 | Second operand; not used in the conversion modes |
| mode_i | input | 2 | 00 add, 01 subtract, 10 BCD to Excess-3, 11 Excess-3 to BCD |
| sum_o | output | 4 | Raw adder result |
| carry_o | output | 1 | Adder carry-out |
| neg_o | output | 1 | Subtract result is negative |
| mag_o | output | 4 | Absolute value of the result |
| code_bad_o | output | 1 | Conversion input is outside the legal code range |

## Verification
The bench builds the unit with its default width of four bits. At that width the whole input space is 1024 vectors, so the bench can sweep every mode, every operand pair and every digit exhaustively. That sweep reaches every carry and borrow boundary, every edge of the two code ranges, and every case where b_i is ignored. A seeded random pass and the fixed subtraction examples run on top of the sweep.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD      = 2'b00,
    OP_SUB      = 2'b01,
    OP_TO_XS3   = 2'b10,
    OP_FROM_XS3 = 2'b11
  } op_e;
endpackage

// File: rtl/addsub_opsel.sv
// Chooses the adder's second operand and carry-in from the mode.
module addsub_opsel
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  op_e          op_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_eff_o,
  output logic         cin_o
);
  localparam logic [W-1:0] XS3_BIAS = W'(3);

  logic [W-1:0] raw;
  logic         invert;

  always_comb begin
    raw    = b_i;
    invert = 1'b0;
    unique case (op_i)
      OP_ADD:      begin raw = b_i;      invert = 1'b0; end
      OP_SUB:      begin raw = b_i;      invert = 1'b1; end
      OP_TO_XS3:   begin raw = XS3_BIAS; invert = 1'b0; end
      OP_FROM_XS3: begin raw = XS3_BIAS; invert = 1'b1; end
      default:     begin raw = b_i;      invert = 1'b0; end
    endcase
  end

  // The complementing path is an XOR with the invert control on every bit.
  assign b_eff_o = raw ^ {W{invert}};
  assign cin_o   = invert;

  // Constant-operand modes must never pass b_i through.
  always_comb begin
    if (op_i == OP_TO_XS3)
      assert_const_to_R5: assert (b_eff_o == XS3_BIAS && !cin_o)
        else $error("to-xs3 operand not constant");
    if (op_i == OP_FROM_XS3)
      assert_const_from_R6: assert ((b_eff_o ^ XS3_BIAS) == {W{1'b1}} && cin_o)
        else $error("from-xs3 operand not complemented constant");
  end
endmodule

// File: rtl/addsub_ripple.sv
// Ripple-carry adder built from a generated chain of full adders.
module addsub_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar k = 0; k < W; k++) begin : g_fa
    logic p, g;
    assign p        = a_i[k] ^ b_i[k];
    assign g        = a_i[k] & b_i[k];
    assign sum_o[k] = p ^ c[k];
    assign c[k+1]   = g | (p & c[k]);
  end

  assign cout_o = c[W];

  always_comb begin
    assert_chain_R1: assert ({cout_o, sum_o} ==
                             ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("ripple chain sum mismatch");
  end
endmodule

// File: rtl/addsub_post.sv
// Sign, magnitude and code-range flag derived from the adder result.
module addsub_post
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] sum_i,
  input  logic         cout_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o,
  output logic         code_bad_o
);
  localparam logic [W-1:0] BCD_MAX = W'(9);
  localparam logic [W-1:0] XS3_MIN = W'(3);
  localparam logic [W-1:0] XS3_MAX = W'(12);
  localparam logic [W-1:0] ONE     = W'(1);

  assign neg_o = (op_i == OP_SUB) && !cout_i;
  assign mag_o = neg_o ? ((~sum_i) + ONE) : sum_i;

  always_comb begin
    unique case (op_i)
      OP_TO_XS3:   code_bad_o = (a_i > BCD_MAX);
      OP_FROM_XS3: code_bad_o = (a_i < XS3_MIN) || (a_i > XS3_MAX);
      default:     code_bad_o = 1'b0;
    endcase
  end

  always_comb begin
    assert_mag_R4: assert (!neg_o || ((mag_o + sum_i) == '0 && mag_o != '0))
      else $error("magnitude is not the negation of a negative result");
    assert_sign_R3: assert (!neg_o || op_i == OP_SUB)
      else $error("sign flag outside subtract mode");
    assert_flag_R7: assert (!code_bad_o || op_i[1])
      else $error("code flag in arithmetic mode");
  end
endmodule

// File: rtl/addsub_codeconv.sv
module addsub_codeconv
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         neg_o,
  output logic [W-1:0] mag_o,
  output logic         code_bad_o
);
  localparam logic [W-1:0] XS3_BIAS = W'(3);

  op_e          op;
  logic [W-1:0] b_eff;
  logic         cin;

  assign op = op_e'(mode_i);

  addsub_opsel #(.W(W)) u_opsel (
    .op_i(op), .b_i(b_i), .b_eff_o(b_eff), .cin_o(cin)
  );

  addsub_ripple #(.W(W)) u_adder (
    .a_i(a_i), .b_i(b_eff), .cin_i(cin), .sum_o(sum_o), .cout_o(carry_o)
  );

  addsub_post #(.W(W)) u_post (
    .op_i(op), .a_i(a_i), .sum_i(sum_o), .cout_i(carry_o),
    .neg_o(neg_o), .mag_o(mag_o), .code_bad_o(code_bad_o)
  );

  always_comb begin
    if (op == OP_SUB) begin
      assert_sub_R2: assert (sum_o == W'(a_i - b_i) && carry_o == (a_i >= b_i))
        else $error("subtract result wrong");
    end
    if (op == OP_TO_XS3) begin
      assert_to_R5: assert (sum_o == W'(a_i + XS3_BIAS))
        else $error("bcd to xs3 wrong");
    end
    if (op == OP_FROM_XS3) begin
      assert_from_R6: assert (sum_o == W'(a_i - XS3_BIAS) && carry_o == (a_i >= XS3_BIAS))
        else $error("xs3 to bcd wrong");
    end
  end
endmodule

// File: tb/tb_addsub_codeconv.sv
module tb_addsub_codeconv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] a, b, sum, mag;
  logic [1:0] mode;
  logic carry, neg, bad;
  int errors = 0, checks = 0;
  bit done = 0;

  addsub_codeconv dut (
    .a_i(a), .b_i(b), .mode_i(mode), .sum_o(sum), .carry_o(carry),
    .neg_o(neg), .mag_o(mag), .code_bad_o(bad)
  );

  function automatic int exp_sum(int m, int x, int y);
    case (m)
      0: return (x + y) % 16;
      1: return (x - y + 16) % 16;
      2: return (x + 3) % 16;
      default: return (x - 3 + 16) % 16;
    endcase
  endfunction
  function automatic int exp_carry(int m, int x, int y);
    case (m)
      0: return (x + y) >= 16;
      1: return x >= y;
      2: return (x + 3) >= 16;
      default: return x >= 3;
    endcase
  endfunction
  function automatic int exp_neg(int m, int x, int y);
    return (m == 1) && (x < y);
  endfunction
  function automatic int exp_mag(int m, int x, int y);
    if (m == 1) return (x >= y) ? x - y : y - x;
    return exp_sum(m, x, y);
  endfunction
  function automatic int exp_bad(int m, int x);
    if (m == 2) return x > 9;
    if (m == 3) return (x < 3) || (x > 12);
    return 0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (mode=%0d a=%0d b=%0d)", tag, got, exp, mode, a, b);
    end
  endtask

  function automatic string rtag(int m, string sub);
    case (m)
      0: return {"R1 ", sub};
      1: return {"R2 ", sub};
      2: return {"R5 ", sub};
      default: return {"R6 ", sub};
    endcase
  endfunction

  task automatic apply(int m, int x, int y);
    @(posedge clk);
    mode = 2'(m); a = 4'(x); b = 4'(y);
    @(negedge clk);
    chk(rtag(m, "sum"), sum, exp_sum(m, x, y));
    chk(rtag(m, "carry"), carry, exp_carry(m, x, y));
    chk("R3 neg", neg, exp_neg(m, x, y));
    chk("R4 mag", mag, exp_mag(m, x, y));
    chk("R7 code_bad", bad, exp_bad(m, x));
  endtask

  initial begin
    a = 0; b = 0; mode = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset sum", sum, 0);
    chk("R1 reset carry", carry, 0);
    chk("R3 reset neg", neg, 0);
    chk("R7 reset flag", bad, 0);

    // R8 fixed examples
    apply(1, 8, 3);
    chk("R8 8-3 sum", sum, 5);
    chk("R8 8-3 carry", carry, 1);
    apply(1, 14, 15);
    chk("R8 14-15 sum", sum, 15);
    chk("R8 14-15 carry", carry, 0);
    chk("R8 14-15 neg", neg, 1);
    chk("R8 14-15 mag", mag, 1);

    // Directed corners: equal operands, overflow, wrap in conversions
    apply(1, 0, 0);
    apply(1, 0, 15);
    apply(0, 15, 15);
    apply(0, 15, 1);
    apply(2, 13, 0);
    apply(3, 2, 0);

    // Exhaustive sweep; conversion modes vary b to show it is ignored (R5, R6)
    for (int m = 0; m < 4; m++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          apply(m, x, y);

    // Seeded random pass
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++)
      apply($urandom % 4, $urandom % 16, $urandom % 16);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule